// File: doc/BRIEF.md
# System tick down-counter timer

The block is a memory-mapped periodic down-counter that asks an interrupt controller for service each time the count passes through zero. Software programs a reload value and sets the enable bit. The counter then runs from the reload value down to zero. On the tick taken at zero it reloads and raises an expiry event. Each expiry sets a sticky wrap flag. When interrupts are enabled in the control register, an expiry also drives a one-cycle pend request.

The counter advances on every core clock cycle, or only on cycles where the reference-tick enable input is high. A bit in the control register chooses between the two. Register access uses a simple one-cycle word port with four registers, selected by `addr_i`. A write takes effect at the clock edge of the access. Read data is registered and appears on `rdata_o` in the cycle after the read, then holds until the next read.

Top module: `systick_timer`

## Requirements
- R1: After reset, enable, interrupt-enable, source select, wrap flag, reload, count, `pend_o` and `rdata_o` are all zero.
- R2: Address 0 is control/status. Bit 0 is enable, bit 1 is interrupt-on-wrap, bit 2 is source select (1 = every core cycle, 0 = only cycles with `ref_tick_i` high), and bit 16 is the wrap flag. A write stores only bits [2:0]. A write of 1 to bit 16 does not set the flag.
- R3: A control read returns the flag as it was before the read, then clears the flag. The exception is an expiry in the same cycle: the flag is then set.
- R4: While enabled, the counter decrements on each tick. A tick taken at count zero is an expiry: it reloads the count, so the period is reload+1 ticks. An expiry sets the flag. If bit 1 is set, it also raises `pend_o` for exactly one cycle, in the cycle after the expiry tick.
- R5: An expiry with reload value zero clears the enable bit, unless a control write lands in the same cycle.
- R6: A write to address 2, whatever its data, loads the count from reload and clears the flag. It takes priority over a tick in that cycle.
- R7: A read of address 2 returns the count while enabled and zero while disabled.
- R8: A read of address 3 returns the constant 10000.
- R9: A control write that keeps enable set but changes the source bit loads the count from reload.
- R10: While disabled, the count holds its value. Setting enable again resumes from that value. Only if the count is zero is it first loaded from reload.
- R11: Address 1 holds a 24-bit reload value. Data bits [31:24] of a write are dropped, and a read returns them as zero.
- R12: Read data appears in the cycle after the read and holds until the next read. Writes do not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | Reference-tick enable, one core cycle wide |
| req_i | input | 1 | Register access in this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Word select: 0 control, 1 reload, 2 current, 3 calibration |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| pend_o | output | 1 | One-cycle exception pend request |

## Verification
The assertions take for granted that there is at most one register access per cycle and that all inputs are known from the end of reset onward. The two-bit address means every access selects a defined register. The properties also assume that the reference tick is only sampled at clock edges, and the bench changes every input only on the falling edge. The random stimulus keeps reload values small so that expiries, auto-stops at reload zero and back-to-back restarts occur often. It mixes control writes of random bit patterns with frequent control and current-value reads, so that read-clear of the flag meets expiry in the same cycle.

// File: rtl/systick_pkg.sv
package systick_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL    = 2'd0,
    SEL_RELOAD  = 2'd1,
    SEL_CURRENT = 2'd2,
    SEL_CALIB   = 2'd3
  } reg_sel_e;

  localparam int unsigned FLAG_BIT = 16;

  typedef struct packed {
    logic src;     // 1: core clock, 0: reference tick
    logic int_en;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/systick_regs.sv
module systick_regs
  import systick_pkg::*;
#(
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CALIB_VAL = 10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              expire_i,
  output ctrl_t             ctrl_o,
  output logic              flag_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              reload_now_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned PAD_W = DATA_W - CNT_W;

  ctrl_t             ctrl_q, ctrl_wr;
  logic              flag_q;
  logic [CNT_W-1:0]  reload_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rd, wr_ctrl, wr_reload, wr_cur, rd_ctrl;
  logic              src_swap, fresh_start;
  logic              unused_w;

  assign rd        = req_i & ~we_i;
  assign wr_ctrl   = req_i & we_i & (addr_i == SEL_CTRL);
  assign wr_reload = req_i & we_i & (addr_i == SEL_RELOAD);
  assign wr_cur    = req_i & we_i & (addr_i == SEL_CURRENT);
  assign rd_ctrl   = rd & (addr_i == SEL_CTRL);
  assign ctrl_wr   = ctrl_t'(wdata_i[2:0]);
  assign unused_w  = ^wdata_i[DATA_W-1:CNT_W];

  // reload triggers from control writes
  assign src_swap     = wr_ctrl & ctrl_q.en & ctrl_wr.en & (ctrl_wr.src != ctrl_q.src);
  assign fresh_start  = wr_ctrl & ~ctrl_q.en & ctrl_wr.en & (count_i == '0);
  assign reload_now_o = wr_cur | src_swap | fresh_start;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= ctrl_wr;
    end else if (expire_i && reload_q == '0) begin
      ctrl_q.en <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (expire_i) begin
      flag_q <= 1'b1;
    end else if (wr_cur || rd_ctrl) begin
      flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
    end else if (wr_reload) begin
      reload_q <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata_d = '0;
    unique case (reg_sel_e'(addr_i))
      SEL_CTRL: begin
        rdata_d[2:0]     = ctrl_q;
        rdata_d[FLAG_BIT] = flag_q;
      end
      SEL_RELOAD:  rdata_d = {{PAD_W{1'b0}}, reload_q};
      SEL_CURRENT: rdata_d = ctrl_q.en ? {{PAD_W{1'b0}}, count_i} : '0;
      SEL_CALIB:   rdata_d = DATA_W'(CALIB_VAL);
      default:     rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (rd) begin
      rdata_q <= rdata_d;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign flag_o   = flag_q;
  assign reload_o = reload_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/systick_counter.sv
module systick_counter
  import systick_pkg::*;
#(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ctrl_t            ctrl_i,
  input  logic             ref_tick_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             reload_now_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o,
  output logic             pend_o
);
  logic [CNT_W-1:0] count_q;
  logic             tick, step, at_zero;
  logic             pend_q;

  assign tick     = ctrl_i.src ? 1'b1 : ref_tick_i;
  assign step     = ctrl_i.en & tick & ~reload_now_i;
  assign at_zero  = (count_q == '0);
  assign expire_o = step & at_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else if (reload_now_i || expire_o) begin
      count_q <= reload_i;
    end else if (step) begin
      count_q <= count_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= expire_o & ctrl_i.int_en;
  end

  assign count_o = count_q;
  assign pend_o  = pend_q;
endmodule

// File: rtl/systick_timer.sv
module systick_timer
  import systick_pkg::*;
#(
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CALIB_VAL = 10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              pend_o
);
  ctrl_t            ctrl;
  logic             flag;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] count;
  logic             reload_now;
  logic             expire;

  systick_regs #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .CALIB_VAL(CALIB_VAL)
  ) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .we_i         (we_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .count_i      (count),
    .expire_i     (expire),
    .ctrl_o       (ctrl),
    .flag_o       (flag),
    .reload_o     (reload),
    .reload_now_o (reload_now),
    .rdata_o      (rdata_o)
  );

  systick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_i       (ctrl),
    .ref_tick_i   (ref_tick_i),
    .reload_i     (reload),
    .reload_now_i (reload_now),
    .count_o      (count),
    .expire_o     (expire),
    .pend_o       (pend_o)
  );
endmodule

// File: rtl/systick_checker.sv
module systick_checker #(
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CALIB_VAL = 10000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [1:0]        addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              pend_o,
  input logic              en,
  input logic              flag,
  input logic [CNT_W-1:0]  reload,
  input logic [CNT_W-1:0]  count,
  input logic              expire,
  input logic              reload_now
);
  logic rd_ctrl, rd_cur, rd_cal, wr_ctrl, wr_rel, wr_cur;
  assign rd_ctrl = req_i & ~we_i & (addr_i == 2'd0);
  assign rd_cur  = req_i & ~we_i & (addr_i == 2'd2);
  assign rd_cal  = req_i & ~we_i & (addr_i == 2'd3);
  assign wr_ctrl = req_i & we_i & (addr_i == 2'd0);
  assign wr_rel  = req_i & we_i & (addr_i == 2'd1);
  assign wr_cur  = req_i & we_i & (addr_i == 2'd2);

  AST_PEND_HAS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o |-> flag); // R4
  AST_RD_CTRL_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ctrl |=> rdata_o[16] == $past(flag)); // R3
  AST_RD_CTRL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ctrl && !expire) |=> !flag); // R3
  AST_AUTO_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && reload == '0 && !wr_ctrl) |=> !en); // R5
  AST_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cur |=> (count == $past(reload)) && !flag); // R6
  AST_CUR_ZERO_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_cur && !en) |=> rdata_o == '0); // R7
  AST_CALIB_CONST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cal |=> rdata_o == DATA_W'(CALIB_VAL)); // R8
  AST_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !reload_now) |=> $stable(count)); // R10
  AST_RELOAD_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_rel |=> reload == $past(wdata_i[CNT_W-1:0])); // R11
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o)); // R12
endmodule

bind systick_timer systick_checker #(
  .CNT_W(CNT_W), .DATA_W(DATA_W), .CALIB_VAL(CALIB_VAL)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .pend_o     (pend_o),
  .en         (ctrl.en),
  .flag       (flag),
  .reload     (reload),
  .count      (count),
  .expire     (expire),
  .reload_now (reload_now)
);

// File: tb/sim_systick_timer.sv
`timescale 1ns/1ps
module sim_systick_timer;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ref_tick = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        pend;

  int n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  systick_timer u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ref_tick_i(ref_tick),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pend_o(pend)
  );

  // requirement-level expectation state
  logic        m_en, m_ie, m_src, m_flag, m_pend;
  logic [23:0] m_rel, m_cnt;
  logic [31:0] m_rd;

  function automatic logic [31:0] exp_read(input logic [1:0] a);
    logic [31:0] v = 32'd0;
    case (a)
      2'd0: begin v[2:0] = {m_src, m_ie, m_en}; v[16] = m_flag; end
      2'd1: v = {8'd0, m_rel};
      2'd2: v = m_en ? {8'd0, m_cnt} : 32'd0;
      default: v = 32'd10000;
    endcase
    return v;
  endfunction

  task automatic model_reset();
    m_en = 0; m_ie = 0; m_src = 0; m_flag = 0; m_pend = 0;
    m_rel = 0; m_cnt = 0; m_rd = 0;
  endtask

  task automatic model_step(input logic rq, input logic w, input logic [1:0] a,
                            input logic [31:0] d, input logic tk);
    logic rdx, wc, wcur, tick, ld, ex;
    rdx  = rq & ~w;
    wc   = rq & w & (a == 2'd0);
    wcur = rq & w & (a == 2'd2);
    tick = m_src ? 1'b1 : tk;
    ld   = wcur | (wc & m_en & d[0] & (d[2] != m_src)) | (wc & ~m_en & d[0] & (m_cnt == 0));
    ex   = ~ld & m_en & tick & (m_cnt == 0);
    if (rdx) m_rd = exp_read(a);
    m_pend = ex & m_ie;
    if (ld || ex) m_cnt = m_rel;
    else if (m_en && tick) m_cnt = m_cnt - 24'd1;
    if (ex) m_flag = 1;
    else if (wcur || (rdx && a == 2'd0)) m_flag = 0;
    if (wc) {m_src, m_ie, m_en} = d[2:0];
    else if (ex && m_rel == 0) m_en = 0;
    if (rq && w && a == 2'd1) m_rel = d[23:0];
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic rq, input logic w, input logic [1:0] a,
                     input logic [31:0] d, input logic tk);
    @(negedge clk);
    req = rq; we = w; addr = a; wdata = d; ref_tick = tk;
    @(posedge clk);
    model_step(rq, w, a, d, tk);
    #1;
    chk("R4 pend", {31'd0, pend}, {31'd0, m_pend});
    if (rq && !w) begin
      case (a)
        2'd0: chk("R3 ctrl read", rdata, m_rd);
        2'd1: chk("R11 reload read", rdata, m_rd);
        2'd2: chk("R7 current read", rdata, m_rd);
        default: chk("R8 calib read", rdata, m_rd);
      endcase
    end else begin
      chk("R12 rdata hold", rdata, m_rd);
    end
  endtask

  task automatic idle(input logic tk);
    cyc(1'b0, 1'b0, 2'd0, 32'd0, tk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int first_p, second_p;
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 pend reset", {31'd0, pend}, 32'd0);
    chk("R1 rdata reset", rdata, 32'd0);
    @(negedge clk); rst_ni = 1'b1;

    cyc(1, 0, 2'd0, 0, 0);           chk("R1 ctrl after reset", rdata, 32'h0);
    cyc(1, 1, 2'd1, 32'hFFFF_FFFF, 0);
    cyc(1, 0, 2'd1, 0, 0);           chk("R11 reload upper bits", rdata, 32'h00FF_FFFF);
    cyc(1, 1, 2'd3, 32'h1234, 0);    chk("R12 write leaves rdata", rdata, 32'h00FF_FFFF);
    cyc(1, 0, 2'd3, 0, 0);           chk("R8 calibration", rdata, 32'd10000);
    cyc(1, 1, 2'd0, 32'h0001_0006, 0);
    cyc(1, 0, 2'd0, 0, 0);           chk("R2 ctrl write mask", rdata, 32'h6);
    cyc(1, 0, 2'd2, 0, 0);           chk("R7 current when off", rdata, 32'h0);

    // period check, core clock, reload 3
    cyc(1, 1, 2'd1, 32'd3, 0);
    cyc(1, 1, 2'd0, 32'd7, 0);
    first_p = -1; second_p = -1;
    for (int i = 1; i <= 12; i++) begin
      idle(0);
      if (pend) begin
        if (first_p < 0) first_p = i;
        else if (second_p < 0) second_p = i;
      end
    end
    chk("R4 first expiry tick", first_p, 4);
    chk("R4 period reload+1", second_p - first_p, 4);

    cyc(1, 1, 2'd0, 32'd6, 0);       // disable, flag still set
    cyc(1, 0, 2'd0, 0, 0);           chk("R3 flag read", rdata, 32'h0001_0006);
    cyc(1, 0, 2'd0, 0, 0);           chk("R3 flag cleared", rdata, 32'h6);

    // freeze and resume
    cyc(1, 1, 2'd0, 32'd7, 0);
    cyc(1, 1, 2'd2, 32'hDEAD, 0);
    idle(0);
    cyc(1, 1, 2'd0, 32'd6, 0);
    repeat (5) idle(0);
    cyc(1, 1, 2'd0, 32'd7, 0);
    cyc(1, 0, 2'd2, 0, 0);           chk("R10 resume from frozen", rdata, 32'd1);

    // restart by writing current
    cyc(1, 1, 2'd2, 32'h0, 0);
    cyc(1, 0, 2'd2, 0, 0);           chk("R6 restart loads reload", rdata, 32'd3);
    cyc(1, 0, 2'd0, 0, 0);           chk("R6 restart clears flag", rdata, 32'h7);

    // source change reloads; reference tick gating
    cyc(1, 1, 2'd2, 32'h0, 0);
    idle(0);
    cyc(1, 1, 2'd0, 32'd3, 0);
    cyc(1, 0, 2'd2, 0, 0);           chk("R9 source swap reload", rdata, 32'd3);
    cyc(1, 0, 2'd2, 0, 0);           chk("R9 no ref tick holds", rdata, 32'd3);
    cyc(1, 0, 2'd2, 0, 1);           chk("R9 ref tick counts a", rdata, 32'd3);
    cyc(1, 0, 2'd2, 0, 0);           chk("R9 ref tick counts b", rdata, 32'd2);

    // reload zero stops at expiry
    cyc(1, 1, 2'd1, 32'd0, 0);
    cyc(1, 1, 2'd0, 32'd7, 0);
    idle(0);                         chk("R5 expiry pend", {31'd0, pend}, 32'd1);
    cyc(1, 0, 2'd0, 0, 0);           chk("R5 enable cleared", rdata, 32'h0001_0006);
    cyc(1, 0, 2'd2, 0, 0);           chk("R7 current after stop", rdata, 32'd0);

    // constrained random phase
    for (int k = 0; k < 5000; k++) begin
      int unsigned r;
      logic tk;
      logic [31:0] d;
      r  = $urandom % 16;
      tk = ($urandom % 3) == 0;
      if (r < 5) idle(tk);
      else if (r < 8) cyc(1, 0, 2'($urandom % 4), 0, tk);
      else if (r == 8) begin
        d = $urandom;
        if (($urandom % 4) != 0) d[0] = 1'b1;
        cyc(1, 1, 2'd0, d, tk);
      end else if (r == 9) begin
        d = (($urandom % 8) == 0) ? $urandom : ($urandom % 6);
        cyc(1, 1, 2'd1, d, tk);
      end else if (r == 10) cyc(1, 1, 2'd2, $urandom, tk);
      else if (r < 13) cyc(1, 0, 2'd0, 0, tk);
      else cyc(1, 0, 2'd2, 0, tk);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule